// File: doc/BRIEF.md
# Register-Access Intercept Lookup

This block decides whether a guest's read or write of a model-specific register must leave the guest and go to the hypervisor. A request carries the access direction, a 32-bit register index and the state of the "use permission bitmap" execution control. When the control is set and the index lies in one of the two covered windows, the block reads one byte from a 4 KiB permission page over a simple synchronous byte port and picks out a single bit. A set bit means "exit" and a clear bit means "let the guest proceed". In every other case the block answers "exit" without touching the page.

The page is split into four 1 KiB quarters. Bit 11 of the byte address selects write (1) or read (0). Bit 10 selects the high window (1) or the low window (0). The low window is indices 0x00000000 to 0x00001FFF. The high window is indices 0xC0000000 to 0xC0001FFF. The quarters therefore start at 0x000 (low reads), 0x400 (high reads), 0x800 (low writes) and 0xC00 (high writes).

A state machine steps through four named states:
- `ST_IDLE`: ready for a request.
- `ST_FETCH`: the single page read is issued.
- `ST_SAMPLE`: the returned byte arrives and the bit is latched.
- `ST_FINISH`: one-cycle done pulse that carries the verdict.

It has four transitions:
- IDLE→FETCH when a request is accepted that needs the page.
- IDLE→FINISH when a request is accepted that does not need the page.
- FETCH→SAMPLE and SAMPLE→FINISH unconditionally.
- FINISH→IDLE unconditionally.

Top module: `msr_icpt_chk`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `resp_done`=0 and `mem_rd_en`=0.
- R2: With `use_bitmap`=0 an accepted request returns `resp_exit`=1 with `resp_done` in the first cycle after acceptance, and no page read is issued.
- R3: An index whose bits 31:13 are neither 0 nor 0x60000 returns `resp_exit`=1 one cycle after acceptance, and no page read is issued, whatever `use_bitmap` is.
- R4: For a covered index with `use_bitmap`=1 the page read address is {write, high, index[12:3]}: bit 11 is 1 for a write, bit 10 is 1 for the 0xC0000000 window, and bits 9:0 are index bits 12:3.
- R5: The verdict is bit index[2:0] of the byte returned. A 1 gives `resp_exit`=1 and a 0 gives `resp_exit`=0.
- R6: A lookup issues exactly one one-cycle read, in the cycle after acceptance, and `resp_done` rises three cycles after acceptance. The read data is taken one cycle after `mem_rd_en`.
- R7: `resp_done` is a single-cycle pulse. `req_ready` is low from acceptance until done. A request presented while busy is ignored: it produces no read and no extra done.
- R8: The edges of each window are handled exactly: 0x1FFF and 0xC0001FFF are looked up, while 0x2000, 0xBFFFFFFF and 0xC0002000 always exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_index | input | 32 | Register index |
| use_bitmap | input | 1 | Permission bitmap control enabled |
| mem_rd_en | output | 1 | Page read strobe |
| mem_addr | output | 12 | Page byte address |
| mem_rd_data | input | 8 | Page byte, valid one cycle after strobe |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_exit | output | 1 | Verdict while done: 1 = exit, 0 = pass |

## Verification
The assertions check the following on every cycle:
- the done pulse width;
- that `req_ready` is low while a read is in flight;
- the bypass timing and verdict for a disabled control or an uncovered index;
- the read strobe position and its computed address;
- the read-to-done spacing.

Only the bench scenarios can show that the verdict equals the selected bit of the page byte. The same holds for the exact window edges, and for requests offered while busy leaving no trace afterwards.

// File: rtl/msr_icpt_pkg.sv
package msr_icpt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_SAMPLE = 2'd2,
        ST_FINISH = 2'd3
    } icpt_state_e;

    localparam int QUARTER_SEL_W = 2;

endpackage

// File: rtl/msr_icpt_decode.sv
module msr_icpt_decode #(
    parameter int IDX_W      = 32,
    parameter int RANGE_BITS = 13,
    parameter int BIT_W      = 3,
    parameter logic [IDX_W-1:0] HIGH_BASE = 32'hC000_0000,
    localparam int ADDR_W    = msr_icpt_pkg::QUARTER_SEL_W + RANGE_BITS - BIT_W
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              is_write,
    output logic              covered,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [BIT_W-1:0]  bit_pos
);

    logic in_low;
    logic in_high;

    always_comb begin
        in_low    = (idx[IDX_W-1:RANGE_BITS] == '0);
        in_high   = (idx[IDX_W-1:RANGE_BITS] == HIGH_BASE[IDX_W-1:RANGE_BITS]);
        covered   = in_low | in_high;
        byte_addr = {is_write, in_high, idx[RANGE_BITS-1:BIT_W]};
        bit_pos   = idx[BIT_W-1:0];
    end

endmodule

// File: rtl/msr_icpt_bitsel.sv
module msr_icpt_bitsel #(
    parameter int DATA_W = 8,
    localparam int BIT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [BIT_W-1:0]  pos,
    output logic              bit_val
);

    logic [DATA_W-1:0] hit;

    for (genvar g = 0; g < DATA_W; g++) begin : g_lane
        assign hit[g] = data[g] & (pos == BIT_W'(g));
    end

    assign bit_val = |hit;

endmodule

// File: rtl/msr_icpt_fsm.sv
module msr_icpt_fsm
    import msr_icpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic use_bitmap,
    input  logic covered,
    input  logic bit_val,
    output logic req_ready,
    output logic accept,
    output logic mem_rd_en,
    output logic resp_done,
    output logic resp_exit
);

    icpt_state_e state_q;
    icpt_state_e state_d;
    logic        verdict_q;
    logic        need_page;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign need_page = use_bitmap && covered;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = need_page ? ST_FETCH : ST_FINISH;
            ST_FETCH:  state_d = ST_SAMPLE;
            ST_SAMPLE: state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept && !need_page)
                verdict_q <= 1'b1;
            else if (state_q == ST_SAMPLE)
                verdict_q <= bit_val;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        resp_done = 1'b0;
        resp_exit = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_FETCH:  mem_rd_en = 1'b1;
            ST_SAMPLE: ;
            ST_FINISH: begin
                resp_done = 1'b1;
                resp_exit = verdict_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/msr_icpt_chk.sv
module msr_icpt_chk #(
    parameter int IDX_W      = 32,
    parameter int DATA_W     = 8,
    parameter int RANGE_BITS = 13,
    parameter logic [IDX_W-1:0] HIGH_BASE = 32'hC000_0000,
    localparam int BIT_W     = $clog2(DATA_W),
    localparam int ADDR_W    = msr_icpt_pkg::QUARTER_SEL_W + RANGE_BITS - BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [IDX_W-1:0]  req_index,
    input  logic              use_bitmap,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              resp_done,
    output logic              resp_exit
);

    logic              covered;
    logic [ADDR_W-1:0] addr_d;
    logic [BIT_W-1:0]  pos_d;
    logic [ADDR_W-1:0] addr_q;
    logic [BIT_W-1:0]  pos_q;
    logic              accept;
    logic              bit_val;

    msr_icpt_decode #(
        .IDX_W(IDX_W), .RANGE_BITS(RANGE_BITS), .BIT_W(BIT_W), .HIGH_BASE(HIGH_BASE)
    ) u_decode (
        .idx(req_index), .is_write(req_write),
        .covered(covered), .byte_addr(addr_d), .bit_pos(pos_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            pos_q  <= '0;
        end else if (accept) begin
            addr_q <= addr_d;
            pos_q  <= pos_d;
        end
    end

    msr_icpt_bitsel #(.DATA_W(DATA_W)) u_bitsel (
        .data(mem_rd_data), .pos(pos_q), .bit_val(bit_val)
    );

    msr_icpt_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .use_bitmap(use_bitmap),
        .covered(covered), .bit_val(bit_val), .req_ready(req_ready),
        .accept(accept), .mem_rd_en(mem_rd_en), .resp_done(resp_done),
        .resp_exit(resp_exit)
    );

    assign mem_addr = addr_q;

endmodule

// File: rtl/msr_icpt_sva.sv
module msr_icpt_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        req_write,
    input logic [31:0] req_index,
    input logic        use_bitmap,
    input logic        mem_rd_en,
    input logic [11:0] mem_addr,
    input logic        resp_done,
    input logic        resp_exit
);

    logic idx_low;
    logic idx_high;
    logic take;

    assign idx_low  = (req_index[31:13] == 19'h0);
    assign idx_high = (req_index[31:13] == 19'h60000);
    assign take     = req_valid && req_ready;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !resp_done && !mem_rd_en));

    // R2
    bypass_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !use_bitmap) |=> (resp_done && resp_exit && !mem_rd_en));

    // R3
    bypass_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !idx_low && !idx_high) |=> (resp_done && resp_exit && !mem_rd_en));

    // R4
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && use_bitmap && (idx_low || idx_high)) |=>
            (mem_rd_en && mem_addr == {$past(req_write), $past(idx_high), $past(req_index[12:3])}));

    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R6
    rd_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 resp_done);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    // R7
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || resp_done) |-> !req_ready);

endmodule

bind msr_icpt_chk msr_icpt_sva u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_index(req_index), .use_bitmap(use_bitmap),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .resp_done(resp_done),
    .resp_exit(resp_exit)
);

// File: tb/msr_icpt_chk_bench.sv
module msr_icpt_chk_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_index = '0;
    logic        use_bitmap = 1'b0;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rd_data = '0;
    logic        resp_done;
    logic        resp_exit;

    logic [7:0]  page [4096];
    int          rd_cnt = 0;
    logic [11:0] last_addr = '0;
    int          total = 0;
    int          bad = 0;

    always #10 clk = ~clk;

    msr_icpt_chk u_msr_icpt_chk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_index(req_index), .use_bitmap(use_bitmap),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .resp_done(resp_done), .resp_exit(resp_exit)
    );

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= page[mem_addr];
            last_addr   <= mem_addr;
            rd_cnt      <= rd_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit covered_f(input logic [31:0] i);
        return (i[31:13] == 19'h0) || (i[31:13] == 19'h60000);
    endfunction

    function automatic logic [11:0] addr_f(input logic w, input logic [31:0] i);
        return {w, (i[31:13] == 19'h60000), i[12:3]};
    endfunction

    function automatic logic exp_exit_f(input logic w, input logic [31:0] i, input logic u);
        if (!u || !covered_f(i)) return 1'b1;
        return page[addr_f(w, i)][i[2:0]];
    endfunction

    // one request; optionally offers a second request while busy (R7)
    task automatic run_req(input logic w, input logic [31:0] i, input logic u,
                           input bit offer_busy, input string tag);
        int   lat;
        int   rd0;
        logic exp_e;
        bit   bypass;
        exp_e  = exp_exit_f(w, i, u);
        bypass = !u || !covered_f(i);
        @(negedge clk);
        rd0        = rd_cnt;
        req_write  = w;
        req_index  = i;
        use_bitmap = u;
        req_valid  = 1'b1;
        @(negedge clk);
        lat = 1;
        if (offer_busy) begin
            req_index = i ^ 32'h0000_0155;
            req_write = ~w;
        end else begin
            req_valid = 1'b0;
        end
        while (!resp_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        check(resp_exit == exp_e, {tag, " R5 verdict"}, 32'(resp_exit), 32'(exp_e));
        check(lat == (bypass ? 1 : 3), {tag, " R6 latency"}, lat, bypass ? 1 : 3);
        check((rd_cnt - rd0) == (bypass ? 0 : 1), {tag, " R6 reads"}, rd_cnt - rd0, bypass ? 0 : 1);
        if (!bypass)
            check(last_addr == addr_f(w, i), {tag, " R4 addr"}, 32'(last_addr), 32'(addr_f(w, i)));
        if (offer_busy) begin
            rd0 = rd_cnt;
            lat = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (resp_done) lat++;
            end
            check(lat == 0 && rd_cnt == rd0, {tag, " R7 busy ignored"}, lat + rd_cnt - rd0, 0);
        end
    endtask

    initial begin
        #(20ns * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] idx;
        void'($urandom(32'h5EED_0042));
        for (int a = 0; a < 4096; a++) page[a] = 8'($urandom);
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !resp_done && !mem_rd_en, "R1 reset idle",
              {29'b0, req_ready, resp_done, mem_rd_en}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !resp_done && !mem_rd_en, "R1 after reset",
              {29'b0, req_ready, resp_done, mem_rd_en}, 32'h4);

        // R2: control off, covered index
        run_req(1'b0, 32'h0000_0010, 1'b0, 1'b0, "R2 ctl off rd");
        run_req(1'b1, 32'hC000_0080, 1'b0, 1'b0, "R2 ctl off wr");
        // R3: uncovered indices
        run_req(1'b0, 32'h4000_0000, 1'b1, 1'b0, "R3 mid");
        run_req(1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R3 top");
        // R8: window edges
        run_req(1'b0, 32'h0000_1FFF, 1'b1, 1'b0, "R8 low edge in");
        run_req(1'b1, 32'h0000_2000, 1'b1, 1'b0, "R8 low edge out");
        run_req(1'b0, 32'hBFFF_FFFF, 1'b1, 1'b0, "R8 below high");
        run_req(1'b1, 32'hC000_0000, 1'b1, 1'b0, "R8 high start");
        run_req(1'b1, 32'hC000_1FFF, 1'b1, 1'b0, "R8 high edge in");
        run_req(1'b0, 32'hC000_2000, 1'b1, 1'b0, "R8 high edge out");
        // R5: forced bits in each quarter
        page[12'h000] = 8'h01;  run_req(1'b0, 32'h0000_0000, 1'b1, 1'b0, "R5 set low rd");
        page[12'h000] = 8'hFE;  run_req(1'b0, 32'h0000_0000, 1'b1, 1'b0, "R5 clr low rd");
        page[12'h7FF] = 8'h80;  run_req(1'b0, 32'hC000_1FFF, 1'b1, 1'b0, "R5 set high rd");
        page[12'h801] = 8'hEF;  run_req(1'b1, 32'h0000_000C, 1'b1, 1'b0, "R5 clr low wr");
        page[12'hC02] = 8'h04;  run_req(1'b1, 32'hC000_0012, 1'b1, 1'b0, "R5 set high wr");
        // R7: request offered while busy
        run_req(1'b0, 32'h0000_0123, 1'b1, 1'b1, "R7 busy lookup");
        run_req(1'b1, 32'h1234_5678, 1'b1, 1'b1, "R7 busy bypass");

        // random mix
        for (int n = 0; n < 300; n++) begin
            case ($urandom % 4)
                0:       idx = {19'h0, 13'($urandom)};
                1:       idx = {19'h60000, 13'($urandom)};
                2:       idx = $urandom;
                default: idx = {19'($urandom % 2 ? 19'h1 : 19'h5FFFF), 13'($urandom)};
            endcase
            run_req(1'($urandom), idx, ($urandom % 8) != 0, ($urandom % 16) == 0, "R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule